// File: doc/BRIEF.md
# Invert-and-Select Arithmetic Logic Unit

This block is a purely combinational 32-bit ALU. Its function is chosen by two controls: a 1-bit invert flag that complements the second operand and forces the adder carry-in to one, and a 2-bit selector that routes one of four internal values to the result. The selector picks the bitwise AND, the bitwise OR, the adder output, or a signed less-than flag. Subtraction is therefore addition with the invert flag set, and signed compare reuses the same subtraction.

A zero flag is raised whenever the 32-bit result is all zeros. That flag lets a surrounding datapath decide an equality branch from a subtraction. The unit has no clock and no state. The result follows the operands and controls within one combinational delay.

Top module: `inv_alu`

## Requirements
- R1: With selector 2'b00 the result is the bitwise AND of a_i and b_i, whatever the invert flag.
- R2: With selector 2'b01 the result is the bitwise OR of a_i and b_i, whatever the invert flag.
- R3: With selector 2'b10 and invert flag 0 the result is a_i + b_i modulo 2^32.
- R4: With selector 2'b10 and invert flag 1 the result is a_i - b_i modulo 2^32.
- R5: With selector 2'b11 and invert flag 1, result bit 0 is 1 exactly when a_i < b_i as two's complement values. This holds even when a_i - b_i overflows.
- R6: With selector 2'b11 and invert flag 1, result bits 31 to 1 are 0.
- R7: zero_o is 1 exactly when all 32 result bits are 0, for every selector and invert setting.
- R8: With selector 2'b11 and invert flag 0 the result is 0, so zero_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| b_inv_i | input | 1 | Complement b_i and set the adder carry-in |
| op_sel_i | input | 2 | Result selector: 00 AND, 01 OR, 10 adder, 11 less-than |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The directed cases target signed compare across overflow, for example the most negative value against 1 and the most positive value against -1. A design that takes only the sign of the difference would return the inverted answer in those cases. Wrap-around additions and subtraction of equal operands produce an all-zero result, so the zero flag must rise even though the operands are non-zero. A missing carry-in on subtraction would give a result that is off by one. The unused selector code and the logic selectors with the invert flag set are exercised as well. Leaking the inverted operand into AND/OR, or returning stray data for code 11 without inversion, then shows up as a wrong result.

// File: rtl/inv_alu_pkg.sv
package inv_alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } alu_sel_e;
endpackage

// File: rtl/inv_alu_addsub.sv
module inv_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_inv_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carry;

  assign b_eff    = b_i ^ {WIDTH{b_inv_i}};
  assign carry[0] = b_inv_i;  // +1 completes two's complement negate

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
  end

  assign ovf_o = carry[WIDTH] ^ carry[WIDTH-1];
endmodule

// File: rtl/inv_alu_logic.sv
module inv_alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
endmodule

// File: rtl/inv_alu_zero.sv
module inv_alu_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/inv_alu.sv
module inv_alu
  import inv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_inv_i,
  input  logic [1:0]       op_sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  localparam int PadW = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic             ovf;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic             lt_bit;

  inv_alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .b_inv_i (b_inv_i),
    .sum_o   (sum),
    .ovf_o   (ovf)
  );

  inv_alu_logic #(.WIDTH(WIDTH)) i_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_v),
    .or_o  (or_v)
  );

  // signed less-than: sign of difference corrected by overflow
  assign lt_bit = sum[WIDTH-1] ^ ovf;

  always_comb begin
    unique case (alu_sel_e'(op_sel_i))
      SEL_AND: result_o = and_v;
      SEL_OR:  result_o = or_v;
      SEL_SUM: result_o = sum;
      SEL_SLT: result_o = b_inv_i ? {{PadW{1'b0}}, lt_bit} : '0;
      default: result_o = '0;
    endcase
  end

  inv_alu_zero #(.WIDTH(WIDTH)) i_zero (
    .val_i  (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/inv_alu_chk.sv
module inv_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             b_inv_i,
  input logic [1:0]       op_sel_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);
  always_comb begin
    if (op_sel_i == 2'b00) begin
      assert_and_R1: assert (((result_o & ~a_i) == '0) && ((result_o & ~b_i) == '0)
                             && ((a_i & b_i & ~result_o) == '0));
    end
    if (op_sel_i == 2'b01) begin
      assert_or_R2: assert (((result_o & ~(a_i | b_i)) == '0) && ((a_i & ~result_o) == '0)
                            && ((b_i & ~result_o) == '0));
    end
    if (op_sel_i == 2'b10 && !b_inv_i) begin
      assert_add_R3: assert (WIDTH'(result_o - b_i) == a_i);
    end
    if (op_sel_i == 2'b10 && b_inv_i) begin
      assert_sub_R4: assert (WIDTH'(result_o + b_i) == a_i);
    end
    if (op_sel_i == 2'b11 && b_inv_i) begin
      assert_slt_R5: assert (result_o[0] == ($signed(a_i) < $signed(b_i)));
      assert_slt_pad_R6: assert (result_o[WIDTH-1:1] == '0);
    end
    assert_zero_R7: assert (zero_o == (result_o == '0));
    if (op_sel_i == 2'b11 && !b_inv_i) begin
      assert_unused_R8: assert (zero_o && result_o == '0);
    end
  end
endmodule

bind inv_alu inv_alu_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .b_inv_i  (b_inv_i),
  .op_sel_i (op_sel_i),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/test_inv_alu.sv
module test_inv_alu;
  localparam int  W        = 32;
  localparam time CLK_PER  = 10ns;
  localparam int  WDOG_CYC = 100000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic         inv;
  logic [1:0]   sel;
  logic [W-1:0] res;
  logic         zf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  inv_alu #(.WIDTH(W)) i_inv_alu (
    .a_i(a), .b_i(b), .b_inv_i(inv), .op_sel_i(sel),
    .result_o(res), .zero_o(zf)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y,
                                         logic iv, logic [1:0] s);
    case (s)
      2'b00:   return x & y;
      2'b01:   return x | y;
      2'b10:   return iv ? x - y : x + y;
      default: return iv ? W'($signed(x) < $signed(y)) : '0;
    endcase
  endfunction

  function automatic string tag(logic iv, logic [1:0] s);
    case (s)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return iv ? "R4" : "R3";
      default: return iv ? "R5/R6" : "R8";
    endcase
  endfunction

  task automatic run(logic [W-1:0] x, logic [W-1:0] y, logic iv, logic [1:0] s);
    logic [W-1:0] exp;
    @(posedge clk);
    #1;
    a = x; b = y; inv = iv; sel = s;
    @(negedge clk);
    exp = model(x, y, iv, s);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s result a=%h b=%h inv=%0b sel=%b actual=%h expected=%h",
               tag(iv, s), x, y, iv, s, res, exp);
    end
    checks++;
    if (zf !== (exp == '0)) begin
      fails++;
      $display("FAIL R7 zero a=%h b=%h inv=%0b sel=%b actual=%0b expected=%0b",
               x, y, iv, s, zf, exp == '0);
    end
  endtask

  initial begin
    a = '0; b = '0; inv = 1'b0; sel = 2'b00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state: AND of zeros gives zero result and zero flag (R1, R7)
    checks++;
    if (res !== '0 || zf !== 1'b1) begin
      fails++;
      $display("FAIL R7 idle actual=%h/%0b expected=0/1", res, zf);
    end
    // R1/R2 with invert set: B must not appear inverted
    run(32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1, 2'b00);
    run(32'h0000_0000, 32'h0000_0000, 1'b1, 2'b01);
    run(32'hA5A5_0000, 32'h0000_5A5A, 1'b0, 2'b01);
    // R3 wrap to zero
    run(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'b10);
    // R4 equal operands, carry-in check
    run(32'h1234_5678, 32'h1234_5678, 1'b1, 2'b10);
    run(32'h0000_0000, 32'h0000_0001, 1'b1, 2'b10);
    // R5 overflow corners
    run(32'h8000_0000, 32'h0000_0001, 1'b1, 2'b11);
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b11);
    run(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 2'b11);
    run(32'h0000_0005, 32'h0000_0005, 1'b1, 2'b11);
    run(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'b11);
    // R8 unused combination
    run(32'hDEAD_BEEF, 32'h0000_0001, 1'b0, 2'b11);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      run($urandom, ($urandom % 8 == 0) ? 32'h8000_0000 : $urandom,
          1'($urandom), 2'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_CYC; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule